// File: doc/BRIEF.md
# PWM Compare and Action Qualifier

This block sits behind a free-running time-base counter and turns its count into two pulse-width-modulated outputs, A and B. Two 16-bit compare values are matched against the count. For each output a control word decides what the output does on three timing events: the counter at zero, a match on compare A while counting up, and a match on compare B while counting up. A configuration port writes the compare values, their loading mode, the two control words and a continuous force word.

Each compare value can be written directly into the active copy, or into a holding copy that moves to the active copy at counter zero, at the period strobe, at either one, or never. The force word can hold either output low or high for as long as it is set. While an output is forced, its qualified waveform keeps running internally, so releasing the force brings the output straight back to that waveform.

Each output is a two-state machine. The states are ST_LOW and ST_HIGH. The transitions are: SET moves ST_LOW to ST_HIGH, CLEAR moves ST_HIGH to ST_LOW, TOGGLE flips the state, and NONE holds it. The resolved action of the tick picks the transition, and the state register takes it at the clock edge that ends the tick. An output stage then applies the force on top of the state.

Top module: `pwm_cmp_aq`

## Requirements
- R1: After reset both outputs are low. Every action field is "no action", the force word is off, both compare values (active and holding) are 0, and both compares are in direct-write mode with load code 0.
- R2: A write to address 0 sets compare A and a write to address 1 sets compare B. When the compare's holding-mode bit is 0, the write reaches the active value used from the next tick.
- R3: Address 2 is the compare-load control. Bit 0 is the holding-mode bit of compare A and bits [2:1] are its load code. Bit 4 and bits [6:5] are the same fields for compare B. With the holding bit at 1, writes go to the holding copy, and the holding copy moves to the active value at counter zero (code 0), at the period strobe (code 1), at either (code 2), or never (code 3).
- R4: A compare event fires only in a tick where the direction input says up and the count equals that compare's active value. When the direction is down, only the zero event can act.
- R5: Address 3 holds output A's control word and address 4 holds output B's. In each word, bits [1:0] give the zero action, bits [5:4] the compare-A-up action and bits [9:8] the compare-B-up action. The action codes are 0 none, 1 clear, 2 set and 3 toggle. The output changes at the clock edge that ends the tick holding the event.
- R6: When several events with a non-zero action fall in one tick, the compare-B action wins over the compare-A action, and the compare-A action wins over the zero action.
- R7: With set-on-zero and clear-on-compare-up, and a counter period of P ticks, the output is high for exactly C ticks per period for a compare value C with 0 < C < P. C = 0 gives 0 ticks and C >= P gives P ticks. Swapping set and clear gives P - C ticks, and P ticks when C = 0.
- R8: Address 5 is the force word. Bits [1:0] control output A and bits [3:2] control output B: 1 forces the output low, 2 forces it high, and 0 or 3 leaves it free. The force takes effect the cycle after the write and lasts until it is rewritten. The qualified waveform keeps running underneath, so a freed output follows it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_count | input | 16 | Time-base count value |
| tb_dir_up | input | 1 | 1 while the time base counts up |
| tb_zero | input | 1 | Strobe: count is zero this tick |
| tb_period | input | 1 | Strobe: count is at period this tick |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Configuration write address |
| wr_data | input | 16 | Configuration write data |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
The bench goes after the edges of the duty range. A compare of zero coincides with the zero event, so a design with zero-over-compare priority would give a full period instead of an empty one. A compare at or beyond the period never matches, so a design that wrapped or clamped it would show a short pulse. Two compare actions meeting in one tick expose a wrong priority order, and counting down shows whether a compare event leaks through when the direction is down. For each holding-copy load code, the bench measures the first period after a write: a design that loads at the wrong strobe shows the new duty one period early or late, or never. A released force shows whether the waveform kept running underneath or froze.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_CLR  = 2'd1,
        ACT_SET  = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        LD_ZERO   = 2'd0,
        LD_PRD    = 2'd1,
        LD_EITHER = 2'd2,
        LD_NEVER  = 2'd3
    } load_e;

    typedef enum logic [1:0] {
        FRC_OFF  = 2'd0,
        FRC_LOW  = 2'd1,
        FRC_HIGH = 2'd2,
        FRC_RSVD = 2'd3
    } frc_e;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } lvl_e;

    typedef struct packed {
        act_e on_zero;
        act_e on_cau;
        act_e on_cbu;
    } aq_word_t;

    localparam int ADDR_W    = 3;
    localparam int NUM_CMP   = 2;
    localparam int NUM_CH    = 2;
    localparam logic [ADDR_W-1:0] A_CMP0  = 3'd0;
    localparam logic [ADDR_W-1:0] A_LDCTL = 3'd2;
    localparam logic [ADDR_W-1:0] A_AQ0   = 3'd3;
    localparam logic [ADDR_W-1:0] A_FORCE = 3'd5;

endpackage

// File: rtl/pwm_cmp_reg.sv
module pwm_cmp_reg
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             hold_en,
    input  load_e            load_sel,
    input  logic             ev_zero,
    input  logic             ev_prd,
    output logic [CNT_W-1:0] cmp_active
);

    logic [CNT_W-1:0] hold_q;
    logic             load_hit;

    always_comb begin
        unique case (load_sel)
            LD_ZERO:   load_hit = ev_zero;
            LD_PRD:    load_hit = ev_prd;
            LD_EITHER: load_hit = ev_zero | ev_prd;
            default:   load_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr_sel && hold_en) begin
            hold_q <= wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_active <= '0;
        end else if (wr_sel && !hold_en) begin
            cmp_active <= wr_val;
        end else if (hold_en && load_hit) begin
            cmp_active <= hold_q;
        end
    end

endmodule

// File: rtl/pwm_aq_chan.sv
module pwm_aq_chan
    import pwm_aq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  aq_word_t aq_word,
    input  logic     ev_zero,
    input  logic     ev_cau,
    input  logic     ev_cbu,
    input  frc_e     frc_sel,
    output logic     qual_out,
    output logic     pwm_out
);

    lvl_e state_q;
    lvl_e state_d;
    act_e act_win;

    // Compare B beats compare A beats zero; a "none" field never competes.
    always_comb begin
        if (ev_cbu && aq_word.on_cbu != ACT_NONE) begin
            act_win = aq_word.on_cbu;
        end else if (ev_cau && aq_word.on_cau != ACT_NONE) begin
            act_win = aq_word.on_cau;
        end else if (ev_zero && aq_word.on_zero != ACT_NONE) begin
            act_win = aq_word.on_zero;
        end else begin
            act_win = ACT_NONE;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW: begin
                if (act_win == ACT_SET || act_win == ACT_TGL) begin
                    state_d = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (act_win == ACT_CLR || act_win == ACT_TGL) begin
                    state_d = ST_LOW;
                end
            end
            default: state_d = ST_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        qual_out = (state_q == ST_HIGH);
        unique case (frc_sel)
            FRC_LOW:  pwm_out = 1'b0;
            FRC_HIGH: pwm_out = 1'b1;
            default:  pwm_out = qual_out;
        endcase
    end

endmodule

// File: rtl/pwm_cmp_aq.sv
module pwm_cmp_aq
    import pwm_aq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  tb_count,
    input  logic              tb_dir_up,
    input  logic              tb_zero,
    input  logic              tb_period,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              pwm_a,
    output logic              pwm_b
);

    localparam int LDF_W = 4;

    logic [CNT_W-1:0] cmp_act [NUM_CMP];
    logic [NUM_CMP-1:0] cmp_hit;
    logic [NUM_CMP-1:0] hold_en_q;
    load_e              load_q [NUM_CMP];
    logic [NUM_CH-1:0]  qual_lvl;
    logic [NUM_CH-1:0]  pwm_o;
    wire                ldctl_wr = wr_en && (wr_addr == A_LDCTL);
    wire                force_wr = wr_en && (wr_addr == A_FORCE);

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold_en_q[i] <= 1'b0;
                load_q[i]    <= LD_ZERO;
            end else if (ldctl_wr) begin
                hold_en_q[i] <= wr_data[LDF_W*i];
                load_q[i]    <= load_e'(wr_data[LDF_W*i+1 +: 2]);
            end
        end

        pwm_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_sel     (wr_en && (wr_addr == A_CMP0 + ADDR_W'(i))),
            .wr_val     (wr_data),
            .hold_en    (hold_en_q[i]),
            .load_sel   (load_q[i]),
            .ev_zero    (tb_zero),
            .ev_prd     (tb_period),
            .cmp_active (cmp_act[i])
        );

        assign cmp_hit[i] = tb_dir_up && (tb_count == cmp_act[i]);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        aq_word_t aq_q;
        frc_e     frc_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                aq_q <= '{on_zero: ACT_NONE, on_cau: ACT_NONE, on_cbu: ACT_NONE};
            end else if (wr_en && (wr_addr == A_AQ0 + ADDR_W'(c))) begin
                aq_q.on_zero <= act_e'(wr_data[1:0]);
                aq_q.on_cau  <= act_e'(wr_data[5:4]);
                aq_q.on_cbu  <= act_e'(wr_data[9:8]);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                frc_q <= FRC_OFF;
            end else if (force_wr) begin
                frc_q <= frc_e'(wr_data[2*c +: 2]);
            end
        end

        pwm_aq_chan u_aq (
            .clk      (clk),
            .rst_n    (rst_n),
            .aq_word  (aq_q),
            .ev_zero  (tb_zero),
            .ev_cau   (cmp_hit[0]),
            .ev_cbu   (cmp_hit[1]),
            .frc_sel  (frc_q),
            .qual_out (qual_lvl[c]),
            .pwm_out  (pwm_o[c])
        );
    end

    assign pwm_a = pwm_o[0];
    assign pwm_b = pwm_o[1];

endmodule

// File: rtl/pwm_cmp_aq_chk.sv
module pwm_cmp_aq_chk
    import pwm_aq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tb_dir_up,
    input logic              tb_zero,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [3:0]        wr_frc,
    input logic              pwm_a,
    input logic              pwm_b,
    input logic [NUM_CH-1:0] qual_lvl
);

    // R1: outputs low one edge after reset is seen
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> (!pwm_a && !pwm_b));

    // R4: without the zero strobe and with direction down, no state moves
    a_r4_no_event_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!tb_dir_up && !tb_zero) |=> $stable(qual_lvl));

    // R8: force low on A
    a_r8_force_low_a: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_FORCE && wr_frc[1:0] == 2'd1) |=> !pwm_a);

    // R8: force high on B
    a_r8_force_high_b: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_FORCE && wr_frc[3:2] == 2'd2) |=> pwm_b);

    // R8: released A follows the running qualified level
    a_r8_release_a: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_FORCE && wr_frc[1:0] == 2'd0) |=> (pwm_a == qual_lvl[0]));

endmodule

bind pwm_cmp_aq pwm_cmp_aq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tb_dir_up (tb_dir_up),
    .tb_zero   (tb_zero),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_frc    (wr_data[3:0]),
    .pwm_a     (pwm_a),
    .pwm_b     (pwm_b),
    .qual_lvl  (qual_lvl)
);

// File: tb/pwm_cmp_aq_bench.sv
`timescale 1ns/1ps
module pwm_cmp_aq_bench;

    localparam int PER = 10;
    localparam int NV  = 10;
    // {cmpA, cmpB, aqA, aqB, force, expA, expB}
    localparam logic [83:0] TBL [NV] = '{
        {16'd4,  16'd6,  16'h0012, 16'h0102, 4'h0, 8'd4,  8'd6},
        {16'd0,  16'd0,  16'h0012, 16'h0102, 4'h0, 8'd0,  8'd0},
        {16'd10, 16'd12, 16'h0012, 16'h0102, 4'h0, 8'd10, 8'd10},
        {16'd3,  16'd2,  16'h0021, 16'h0201, 4'h0, 8'd7,  8'd8},
        {16'd0,  16'd9,  16'h0021, 16'h0201, 4'h0, 8'd10, 8'd1},
        {16'd4,  16'd6,  16'h0012, 16'h0102, 4'h1, 8'd0,  8'd6},
        {16'd4,  16'd6,  16'h0012, 16'h0102, 4'h8, 8'd4,  8'd10},
        {16'd4,  16'd6,  16'h0012, 16'h0102, 4'h6, 8'd10, 8'd0},
        {16'd2,  16'd5,  16'h0102, 16'h0012, 4'h0, 8'd5,  8'd2},
        {16'd4,  16'd6,  16'h0012, 16'h0102, 4'hF, 8'd4,  8'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tb_count = 16'hFFFF;
    logic        tb_dir_up = 1'b0;
    logic        tb_zero = 1'b0;
    logic        tb_period = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [15:0] wr_data = 16'd0;
    logic        pwm_a;
    logic        pwm_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_cmp_aq u_pwm_cmp_aq (
        .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .tb_dir_up(tb_dir_up),
        .tb_zero(tb_zero), .tb_period(tb_period), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_period(input bit up, output int ha, output int hb);
        ha = 0; hb = 0;
        for (int k = 0; k < PER; k++) begin
            @(negedge clk);
            tb_count = 16'(k); tb_dir_up = up;
            tb_zero = (k == 0); tb_period = (k == PER - 1);
            @(posedge clk);
            #1;
            ha += int'(pwm_a); hb += int'(pwm_b);
        end
        @(negedge clk);
        tb_count = 16'hFFFF; tb_dir_up = 1'b0; tb_zero = 1'b0; tb_period = 1'b0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #750000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int ha, hb;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset pwm_a", int'(pwm_a), 0);
        chk("R1 reset pwm_b", int'(pwm_b), 0);
        @(negedge clk);
        rst_n = 1'b1;
        run_period(1'b1, ha, hb);
        chk("R1 no-action default A", ha, 0);
        chk("R1 no-action default B", hb, 0);

        // table walk: R2, R5, R7, R8
        for (int v = 0; v < NV; v++) begin
            wr(3'd0, TBL[v][83:68]);
            wr(3'd1, TBL[v][67:52]);
            wr(3'd3, TBL[v][51:36]);
            wr(3'd4, TBL[v][35:20]);
            wr(3'd5, {12'd0, TBL[v][19:16]});
            run_period(1'b1, ha, hb);
            run_period(1'b1, ha, hb);
            chk($sformatf("R7/R8 vec%0d A", v), ha, int'(TBL[v][15:8]));
            chk($sformatf("R7/R8 vec%0d B", v), hb, int'(TBL[v][7:0]));
        end

        // R4: direction down suppresses compare events
        wr(3'd5, 16'h0000);
        run_period(1'b0, ha, hb);
        chk("R4 down-count A", ha, 10);
        chk("R4 down-count B", hb, 10);

        // R6: compare B over compare A
        wr(3'd0, 16'd3); wr(3'd1, 16'd3);
        wr(3'd3, 16'h0001);
        run_period(1'b1, ha, hb);
        wr(3'd3, 16'h0120);
        run_period(1'b1, ha, hb);
        chk("R6 cmpB clear beats cmpA set", ha, 0);
        wr(3'd3, 16'h0210);
        run_period(1'b1, ha, hb);
        chk("R6 cmpB set beats cmpA clear", ha, 7);

        // R5: toggle on zero
        wr(3'd3, 16'h0002);
        run_period(1'b1, ha, hb);
        wr(3'd3, 16'h0003);
        run_period(1'b1, ha, hb);
        chk("R5 toggle first", ha, 0);
        run_period(1'b1, ha, hb);
        chk("R5 toggle second", ha, 10);

        // R3: holding copy and load codes
        wr(3'd3, 16'h0012);
        wr(3'd0, 16'd2);
        wr(3'd2, 16'h0007);
        wr(3'd0, 16'd7);
        run_period(1'b1, ha, hb);
        chk("R3 load never keeps old", ha, 2);
        wr(3'd2, 16'h0003);
        run_period(1'b1, ha, hb);
        chk("R3 load at period, same period", ha, 2);
        run_period(1'b1, ha, hb);
        chk("R3 load at period, next period", ha, 7);
        wr(3'd2, 16'h0001);
        wr(3'd0, 16'd5);
        run_period(1'b1, ha, hb);
        chk("R3 load at zero", ha, 5);
        wr(3'd2, 16'h0005);
        wr(3'd0, 16'd3);
        run_period(1'b1, ha, hb);
        chk("R3 load at either", ha, 3);
        wr(3'd2, 16'h0000);
        wr(3'd0, 16'd8);
        run_period(1'b1, ha, hb);
        chk("R2 direct write", ha, 8);

        report();
    end

endmodule